// File: doc/BRIEF.md
# First-Hit Address Serializer

This block reports, with low latency, which of 64 front-end channels fired first in an event. Each channel presents a hit strobe. A hit is a strobe that goes from low to high. When the block is idle and one or more strobes rise in the same clock cycle, it takes the channel index of the winning strobe. The strobe with the lowest index wins. The block then sends a short frame on one serial line: a single high marker bit, followed by the 6-bit channel address, most significant bit first, one bit per clock cycle.

The serial line runs on a dedicated 160 MHz clock. All inputs are synchronous to that clock. A busy output is high from the marker bit until the block can accept a new hit. During a frame, any new strobe activity is ignored. After the last address bit, the line is held low for two cycles. The block then re-arms and waits for the next rising strobe.

States and transitions:
- `ST_IDLE`: the line is low and busy is low. On **start** (any strobe rises), the block latches the winning address and goes to `ST_FLAG`.
- `ST_FLAG`: the marker bit is on the line. On **mark_done** (unconditional), it goes to `ST_SEND`.
- `ST_SEND`: one address bit is sent each cycle. After the sixth bit, **last_bit** moves it to `ST_REARM`.
- `ST_REARM`: the line is low for the programmed gap. When the gap count runs out, **rearm_done** returns it to `ST_IDLE`.

Top module: `first_hit_ser`

## Requirements
- R1: A strobe that rises while the block is idle starts a frame. The marker bit appears on `ser_o` in the first cycle after the clock edge that samples the rise.
- R2: When several strobes rise in the same cycle, the reported address is the lowest channel index among them.
- R3: The frame begins with exactly one cycle in which `ser_o` is 1 (the marker bit).
- R4: The six cycles after the marker carry the channel address as an unsigned binary number. Bit 5 is sent first and bit 0 last, one bit per cycle.
- R5: `ser_o` is 0 whenever `busy_o` is 0.
- R6: Strobe rises that occur while `busy_o` is 1 do not change the address being sent. They also do not start a later frame.
- R7: After the last address bit, `ser_o` is 0 and `busy_o` is 1 for exactly 2 cycles. `busy_o` is 0 in the cycle after that.
- R8: Only a low-to-high change of a strobe counts as a hit. A strobe that stays high starts no new frame, and a newly rising strobe is reported even if a lower-index strobe is being held high.
- R9: While `rst_n` is low, and in the first cycle after it is released, `busy_o` and `ser_o` are 0.
- R10: `busy_o` is 1 for the whole frame: the marker cycle, the six address cycles and the two gap cycles, 9 cycles in total.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Dedicated serial clock (160 MHz) |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_i | input | 64 | Channel hit strobes, bit n belongs to channel n |
| ser_o | output | 1 | Serial line: marker bit then address, idles low |
| busy_o | output | 1 | High from marker bit through the re-arm gap |

## Verification
Each result has a fixed cycle position relative to the clock edge that samples a rising strobe, called edge E:
- The marker bit is due in the cycle that follows edge E.
- Address bit 5 is due one cycle later, and the remaining address bits follow one per cycle, ending with bit 0 six cycles after the marker.
- The two quiet gap cycles with `busy_o` high come next.
- `busy_o` must be low nine cycles after edge E.

The bench changes the strobes on the falling edge and samples the outputs on each later falling edge, so every sample falls in the middle of the cycle its result belongs to. Strobes that rise during a frame, and strobes held high after it, are checked at those same sample points. The address being sent and the idle line are observed directly.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FLAG  = 2'd1,
        ST_SEND  = 2'd2,
        ST_REARM = 2'd3
    } fhs_state_e;

endpackage

// File: rtl/fhs_hit_edge.sv
module fhs_hit_edge #(
    parameter int N_CH = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit_i,
    output logic [N_CH-1:0] rise_o
);

    logic [N_CH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= hit_i;
        end
    end

    // per-channel rising-edge detect
    for (genvar g = 0; g < N_CH; g++) begin : g_edge
        assign rise_o[g] = hit_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/fhs_prio_enc.sv
module fhs_prio_enc #(
    parameter int N_CH   = 64,
    parameter int ADDR_W = $clog2(N_CH)
) (
    input  logic [N_CH-1:0]   req_i,
    output logic              any_o,
    output logic [ADDR_W-1:0] idx_o
);

    assign any_o = |req_i;

    // scan from the top so the lowest set index is the last one written
    always_comb begin
        idx_o = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = ADDR_W'(i);
            end
        end
    end

endmodule

// File: rtl/fhs_frame_fsm.sv
module fhs_frame_fsm
    import fhs_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int REARM_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ser_o,
    output logic              busy_o
);

    localparam int CNT_W = $clog2(ADDR_W + REARM_CYC + 1);

    fhs_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_FLAG;
                    addr_d  = addr_i;
                end
            end
            ST_FLAG: begin
                state_d = ST_SEND;
                cnt_d   = CNT_W'(ADDR_W - 1);
            end
            ST_SEND: begin
                if (cnt_q == '0) begin
                    state_d = ST_REARM;
                    cnt_d   = CNT_W'(REARM_CYC - 1);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            ST_REARM: begin
                if (cnt_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        ser_o  = 1'b0;
        busy_o = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_FLAG:  ser_o  = 1'b1;
            ST_SEND:  ser_o  = addr_q[cnt_q[$clog2(ADDR_W)-1:0]];
            ST_REARM: ser_o  = 1'b0;
            default:  busy_o = 1'b0;
        endcase
    end

    // R1: an accepted start leads to the marker state
    a_r1_start_to_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_i) |=> (state_q == ST_FLAG));

    // R6: the latched address does not move while a frame is in flight
    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && state_q != ST_REARM) |=> $stable(addr_q));

    // R10: a frame in progress never drops straight back to idle from send
    a_r10_no_skip_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |=> (state_q == ST_SEND || state_q == ST_REARM));

endmodule

// File: rtl/first_hit_ser.sv
module first_hit_ser #(
    parameter int N_CH      = 64,
    parameter int REARM_CYC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] hit_i,
    output logic            ser_o,
    output logic            busy_o
);

    localparam int ADDR_W = $clog2(N_CH);

    logic [N_CH-1:0]   rise;
    logic              rise_any;
    logic [ADDR_W-1:0] rise_idx;

    fhs_hit_edge #(.N_CH(N_CH)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit_i),
        .rise_o (rise)
    );

    fhs_prio_enc #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_prio (
        .req_i (rise),
        .any_o (rise_any),
        .idx_o (rise_idx)
    );

    fhs_frame_fsm #(.ADDR_W(ADDR_W), .REARM_CYC(REARM_CYC)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (rise_any),
        .addr_i  (rise_idx),
        .ser_o   (ser_o),
        .busy_o  (busy_o)
    );

    // R2: the chosen index is a requesting channel
    a_r2_winner_requests: assert property (@(posedge clk) disable iff (!rst_n)
        rise_any |-> rise[rise_idx]);

    // R2: no requesting channel lies below the chosen index
    a_r2_none_below: assert property (@(posedge clk) disable iff (!rst_n)
        rise_any |-> ((rise & ((N_CH'(1) << rise_idx) - N_CH'(1))) == '0));

    // R3: the first busy cycle carries the marker bit
    a_r3_flag_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ser_o);

    // R5: the line is low while idle
    a_r5_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ser_o);

    // R7: the two cycles before busy drops are quiet
    a_r7_rearm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (!$past(ser_o, 1) && !$past(ser_o, 2)));

endmodule

// File: tb/first_hit_ser_tb_top.sv
module first_hit_ser_tb_top;

    localparam int NCH = 64;

    logic           clk;
    logic           rst_n;
    logic [NCH-1:0] hit_i;
    logic           ser_o;
    logic           busy_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    first_hit_ser dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  (hit_i),
        .ser_o  (ser_o),
        .busy_o (busy_o)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic int lowest_set(input logic [NCH-1:0] v);
        for (int i = 0; i < NCH; i++) begin
            if (v[i]) return i;
        end
        return -1;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one frame: vec is applied at a falling edge; extra is raised mid-frame.
    task automatic frame(input logic [NCH-1:0] vec, input logic [NCH-1:0] extra,
                         input bit keep);
        int exp_addr;
        exp_addr = lowest_set(vec & ~hit_i);
        @(negedge clk);
        hit_i = vec;
        @(negedge clk);
        chk("R1 marker after edge", ser_o, 1);
        chk("R10 busy at marker", busy_o, 1);
        for (int b = 5; b >= 0; b--) begin
            @(negedge clk);
            chk("R4 address bit", ser_o, (exp_addr >> b) & 1);
            chk("R10 busy during address", busy_o, 1);
            if (b == 3) hit_i = vec | extra;
        end
        for (int g = 0; g < 2; g++) begin
            @(negedge clk);
            chk("R7 gap line low", ser_o, 0);
            chk("R7 gap busy", busy_o, 1);
        end
        @(negedge clk);
        chk("R7 busy drops after gap", busy_o, 0);
        for (int h = 0; h < 3; h++) begin
            @(negedge clk);
            chk("R6 R8 no frame from held strobes", busy_o, 0);
            chk("R5 idle line low", ser_o, 0);
        end
        if (!keep) begin
            hit_i = '0;
            @(negedge clk);
        end
    endtask

    initial begin
        logic [NCH-1:0] v;
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        hit_i = '0;
        repeat (3) @(negedge clk);
        chk("R9 busy in reset", busy_o, 0);
        chk("R9 line in reset", ser_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 busy after release", busy_o, 0);
        chk("R9 line after release", ser_o, 0);

        // directed corners
        frame(64'h1, '0, 0);                         // channel 0 -> address 0
        frame(64'h8000_0000_0000_0000, '0, 0);       // channel 63 -> all ones
        frame('1, '0, 0);                            // R2: all rise, 0 wins
        frame(64'h0000_0120_0000_0000, '0, 0);       // R2: 37 and 40 -> 37
        frame(64'h0000_0000_0080_0000, 64'h1, 0);    // R6: ch 0 rises mid-frame
        frame(64'h8, '0, 1);                         // hold ch 3 high
        frame(64'h8 | (64'h1 << 40), '0, 0);         // R8: new rise 40 reported

        // constrained random frames
        for (int k = 0; k < 60; k++) begin
            v = {$urandom, $urandom};
            if (k % 3 == 0) v = v & {$urandom, $urandom} & {$urandom, $urandom};
            if (v == '0) v[$urandom_range(NCH - 1, 0)] = 1'b1;
            frame(v, {$urandom, $urandom}, 0);
        end

        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule